// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Model

This block is a synthesizable stand-in for a 16-bit-wide asynchronous static memory. It is meant to sit behind a memory controller in a testbench, so that the controller's strobes can be checked. The pins are active low: chip select, write strobe, output strobe, and one enable for each byte. From these pins the model decodes one of three states: idle (deselected), read, or write. Reads are combinational from the stored array. A write is held open for as long as its qualifying strobes overlap. It is committed byte by byte when that overlap closes.

Nothing is tri-stated. The bidirectional bus is split into an input word, an output word and a two-bit lane-drive vector, and an undriven lane shows zeros on the output word. The model samples its strobes on a free-running clock. Every strobe level must therefore be held across at least one rising edge to be seen. Only the low `DEPTH_W` address bits select a word, so the upper address bits alias.

Top module: `byte_lane_sram`

## Requirements
- R1: While ce_n is high, lane_drive is 2'b00 and data_out is zero, whatever the other pins do. This is also the state seen during and right after reset.
- R2: With ce_n low, oe_n low, we_n high and both byte enables low, lane_drive is 2'b11 and data_out is the full stored word at the addressed location.
- R3: In a read, lane_drive[0] follows ~lb_n and lane_drive[1] follows ~ub_n. A lane that is not driven shows zero in its byte of data_out (bits 7:0 for the low lane, 15:8 for the high lane).
- R4: With oe_n high, or with both ub_n and lb_n high, lane_drive is 2'b00.
- R5: While ce_n and we_n are both low, lane_drive is 2'b00 regardless of oe_n.
- R6: A lane's write window is open while ce_n, we_n and that lane's enable are all low. When the window closes, the byte stored is the data_in byte present at the last rising edge inside the window, at the address present at that edge. It becomes readable after the first rising edge at which the window is seen closed.
- R7: A write with a byte enable held high leaves that byte's stored value unchanged.
- R8: Each lane's write ends on whichever of its strobes releases first. A data change after one lane's enable releases, while the other lane stays open, reaches only the lane still open.
- R9: Address bits at and above DEPTH_W are ignored. Two addresses that differ only in those bits refer to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the strobes |
| rst_n | input | 1 | Active-low reset of the write-window state |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| ub_n | input | 1 | High-byte enable, active low |
| lb_n | input | 1 | Low-byte enable, active low |
| addr | input | ADDR_W | Word address |
| data_in | input | 16 | Write data |
| data_out | output | 16 | Read data, zero on undriven lanes |
| lane_drive | output | 2 | Per-lane output enable, bit 1 high byte, bit 0 low byte |

## Verification
Suppose the per-lane window register or the captured byte holds a wrong value. The fault appears only at the next read of the affected word: a wrong byte in data_out, on the read that follows the commit edge. A fault can also show up as a lane that changed although its enable was held high. The lane-drive decode has no state, so an error there shows on lane_drive in the same cycle that the pins change. Random reads of a shadowed memory therefore catch storage faults one transaction after the write. Directed strobe-release orderings catch a window that closes on the wrong strobe.

// File: rtl/byte_lane_sram.sv
module byte_lane_sram #(
  parameter int ADDR_W  = 18,
  parameter int DEPTH_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       data_in,
  output logic [15:0]       data_out,
  output logic [1:0]        lane_drive
);
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DEPTH  = 1 << DEPTH_W;

  logic [DEPTH_W-1:0] idx;
  logic               unused_hi;
  logic [LANES-1:0]   lane_sel, win, win_q;
  logic               wr_on, rd_on;

  assign idx        = addr[DEPTH_W-1:0];
  assign unused_hi  = ^addr[ADDR_W-1:DEPTH_W];
  assign lane_sel   = {~ub_n, ~lb_n};
  assign wr_on      = ~ce_n & ~we_n;
  assign rd_on      = ~ce_n & ~oe_n & we_n;
  assign win        = {LANES{wr_on}} & lane_sel;
  assign lane_drive = {LANES{rd_on}} & lane_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0]  store [DEPTH];
    logic [LANE_W-1:0]  cap_d;
    logic [DEPTH_W-1:0] cap_a;

    always_ff @(posedge clk) begin
      if (win[g]) begin
        cap_d <= data_in[g*LANE_W +: LANE_W];
        cap_a <= idx;
      end
      if (win_q[g] && !win[g]) store[cap_a] <= cap_d;
    end

    assign data_out[g*LANE_W +: LANE_W] = lane_drive[g] ? store[idx] : '0;
  end
endmodule

module byte_lane_sram_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       data_out,
  input logic [1:0]        lane_drive
);
  a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (lane_drive == 2'b00 && data_out == 16'h0));
  a_r5_no_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |-> lane_drive == 2'b00);
  a_r4_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> lane_drive == 2'b00);
  a_r3_low_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_drive[0] |-> data_out[7:0] == 8'h0);
  a_r3_high_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_drive[1] |-> data_out[15:8] == 8'h0);
  a_r2_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_drive == 2'b11 && $past(lane_drive) == 2'b11 && $stable(addr)) |-> $stable(data_out));
endmodule

bind byte_lane_sram byte_lane_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .addr(addr), .data_out(data_out), .lane_drive(lane_drive)
);

// File: tb/byte_lane_sram_bench.sv
module byte_lane_sram_bench;
  localparam int ADDR_W  = 18;
  localparam int DEPTH_W = 10;
  localparam int DEPTH   = 1 << DEPTH_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] data_in = '0;
  logic [15:0] data_out;
  logic [1:0]  lane_drive;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [15:0] shadow [DEPTH];

  always #2 clk = ~clk;

  byte_lane_sram #(.ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W)) u_byte_lane_sram (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .data_in(data_in),
    .data_out(data_out), .lane_drive(lane_drive)
  );

  function automatic logic [1:0] exp_drive(logic c, logic w, logic o, logic u, logic l);
    return (!c && w && !o) ? {!u, !l} : 2'b00;
  endfunction

  function automatic logic [15:0] exp_data(logic [1:0] drv, logic [15:0] word);
    return {drv[1] ? word[15:8] : 8'h0, drv[0] ? word[7:0] : 8'h0};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [ADDR_W-1:0] a, logic [15:0] d, logic u, logic l, logic o);
    @(negedge clk);
    addr = a; data_in = d; ce_n = 1'b0; we_n = 1'b0; oe_n = o; ub_n = u; lb_n = l;
    #1 check("R5 drive during write", {30'h0, lane_drive}, 32'h0);
    @(negedge clk);
    we_n = 1'b1; ub_n = 1'b1; lb_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    if (!u) shadow[a[DEPTH_W-1:0]][15:8] = d[15:8];
    if (!l) shadow[a[DEPTH_W-1:0]][7:0]  = d[7:0];
  endtask

  task automatic do_read(string req, logic [ADDR_W-1:0] a, logic c, logic o, logic u, logic l);
    logic [1:0] ed;
    @(negedge clk);
    addr = a; ce_n = c; we_n = 1'b1; oe_n = o; ub_n = u; lb_n = l;
    ed = exp_drive(c, 1'b1, o, u, l);
    #1;
    check({req, " lane_drive"}, {30'h0, lane_drive}, {30'h0, ed});
    check({req, " data_out"}, {16'h0, data_out}, {16'h0, exp_data(ed, shadow[a[DEPTH_W-1:0]])});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1 check("R1 reset lane_drive", {30'h0, lane_drive}, 32'h0);
    check("R1 reset data_out", {16'h0, data_out}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < DEPTH; i++) do_write(ADDR_W'(i), 16'(i * 16'h9e37 + 16'h55aa), 1'b0, 1'b0, 1'b1);

    do_read("R2 full word", 18'h00005, 1'b0, 1'b0, 1'b0, 1'b0);
    do_read("R1 deselect", 18'h00005, 1'b1, 1'b0, 1'b0, 1'b0);
    do_read("R3 low only", 18'h00007, 1'b0, 1'b0, 1'b1, 1'b0);
    do_read("R3 high only", 18'h00007, 1'b0, 1'b0, 1'b0, 1'b1);
    do_read("R4 oe high", 18'h00009, 1'b0, 1'b1, 1'b0, 1'b0);
    do_read("R4 both enables high", 18'h00009, 1'b0, 1'b0, 1'b1, 1'b1);

    do_write(18'h00010, 16'hbeef, 1'b1, 1'b0, 1'b0);
    do_read("R7 high byte kept", 18'h00010, 1'b0, 1'b0, 1'b0, 1'b0);
    do_write(18'h00011, 16'hcafe, 1'b0, 1'b1, 1'b0);
    do_read("R7 low byte kept", 18'h00011, 1'b0, 1'b0, 1'b0, 1'b0);

    do_write(18'h3f020, 16'h1234, 1'b0, 1'b0, 1'b1);
    do_read("R9 alias read", 18'h00020, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9 alias value", {16'h0, data_out}, 32'h1234);

    @(negedge clk);
    addr = 18'h00030; data_in = 16'hA1B2; ce_n = 1'b0; we_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    lb_n = 1'b1; data_in = 16'hC3D4;
    @(negedge clk);
    we_n = 1'b1; ub_n = 1'b1;
    @(negedge clk);
    shadow[10'h030] = 16'hC3B2;
    do_read("R8 first release ends lane", 18'h00030, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R6 R8 stored word", {16'h0, data_out}, 32'hC3B2);

    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] ra;
      ra = ADDR_W'($urandom);
      if ($urandom % 2 == 0)
        do_write(ra, 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      else
        do_read("R6 random", ra, ($urandom % 4) == 0, ($urandom % 4) == 0, 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule